// File: doc/BRIEF.md
# Register Upset Scan Monitor

This block watches a bank of data registers that are meant to stay frozen and reports each bit that changes by itself. The bank is reached through a plain addressed readback port: the monitor drives a select address and, a fixed number of cycles later, samples the returned word. The bank holds groups of registers of different widths. Only the valid bits of each register take part in the comparison.

A start pulse makes the monitor read the whole bank once and keep that pass as the reference image. After that, a prescaler built from the clock frequency starts a checking pass at a fixed interval, 100 ms by default. Each checking pass compares every register with its reference word. Each bit that differs adds one to a total upset counter. It also adds one to a rising counter (0 to 1) or a falling counter (1 to 0), because the two directions do not occur equally often. The monitor also keeps the address of the most recent mismatching register. In update mode the reference word takes the new value after a mismatch, so a persistent flip is counted once. In keep mode the original reference stays, and a persistent flip is counted on every pass.

The readback is a fixed-latency select/data port with no handshake. The bank always answers, so there is no back-pressure on either side. The status and counter outputs are plain levels.

Top module: `upset_scan_monitor`

## Requirements
- R1: After reset, all three counters are 0, `armed_o`, `busy_o`, `pass_done_o` and `last_valid_o` are 0, and `rd_sel_o` is 0.
- R2: A `start_i` pulse seen while `busy_o` is 0 clears the counters and the last-address record, drops `armed_o`, and runs a capture pass. A capture pass visits addresses 0 up to NUM_REGS-1 in ascending order and holds each one for RD_LAT+1 cycles. The pass ends with a one-cycle `pass_done_o` pulse NUM_REGS*(RD_LAT+1) cycles after the accepting edge, and `armed_o` rises in that same cycle. A `start_i` seen while `busy_o` is 1 has no effect.
- R3: While armed, a checking pass starts every CLK_HZ/1000*SCAN_MS cycles. Successive `pass_done_o` pulses are therefore exactly that many cycles apart.
- R4: The valid width of a register depends on its address: 0..63 use 32 bits, 64..79 use 34, 80..83 use 36 and 84 uses 38. Readback bits above that width are ignored.
- R5: In a checking pass, each valid bit that differs from the reference adds 1 to `upset_total_o`. A bit that went 0 to 1 also adds 1 to `upset_rise_o`. A bit that went 1 to 0 also adds 1 to `upset_fall_o`.
- R6: With `update_mode_i`=1, a register's reference takes the readback value after a mismatch, so a bit that stays flipped is counted only once.
- R7: With `update_mode_i`=0, the reference stays the same. A flipped bit is counted on every pass until the register returns to its captured value, and from then on nothing is counted.
- R8: After a checking pass that finds mismatches, `last_addr_o` holds the highest mismatching address of that pass and `last_valid_o` is 1. A pass with no mismatch leaves both unchanged.
- R9: Each counter saturates at 2^CNT_W-1 and never wraps.
- R10: Nothing is counted while `armed_o` is 0, including during a capture pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a capture pass and re-arm |
| update_mode_i | input | 1 | 1: refresh the reference after a mismatch; 0: keep the captured reference |
| rd_sel_o | output | ADDR_W (7) | Register select address sent to the bank |
| rd_data_i | input | DATA_W (38) | Readback word, valid RD_LAT cycles after the select changes |
| armed_o | output | 1 | Reference captured; periodic checking active |
| busy_o | output | 1 | A pass is in progress |
| pass_done_o | output | 1 | One-cycle pulse at the end of each pass |
| upset_total_o | output | CNT_W | Saturating count of all flipped bits |
| upset_rise_o | output | CNT_W | Saturating count of 0-to-1 flips |
| upset_fall_o | output | CNT_W | Saturating count of 1-to-0 flips |
| last_addr_o | output | ADDR_W (7) | Address of the most recent mismatching register |
| last_valid_o | output | 1 | `last_addr_o` holds a mismatch |

## Verification
The bank is filled with random words that carry random bits above each register's valid width, and a shortened scan period is used. Directed flips test the width map:
- A flip above the valid width of a 32-bit register must be ignored.
- A flip inside a 34-bit register's extra bits must be counted.
- A flip in the top bit of the single 38-bit register must be counted.

Flips that persist over several passes, under each mode, separate single counting from repeated counting. Restoring a register to its captured value confirms that keep mode compares against the original image rather than the last readback. Random flip rounds with a random mode per pass check the direction split against a bench model. Inverting the whole bank drives every counter into saturation.

// File: rtl/usm_pkg.sv
package usm_pkg;

  // Valid width of a register from its address: four groups, each STEP bits wider.
  function automatic int unsigned width_of(input int unsigned addr,
                                           input int unsigned n0,
                                           input int unsigned n1,
                                           input int unsigned n2,
                                           input int unsigned base,
                                           input int unsigned step);
    if (addr < n0)                width_of = base;
    else if (addr < n0 + n1)      width_of = base + step;
    else if (addr < n0 + n1 + n2) width_of = base + 2 * step;
    else                          width_of = base + 3 * step;
  endfunction

endpackage

// File: rtl/usm_tick_gen.sv
module usm_tick_gen #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!en)  cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usm_scan_seq.sv
module usm_scan_seq #(
  parameter int unsigned NUM_REGS = 85,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              tick,
  output logic              busy,
  output logic              capture,
  output logic [ADDR_W-1:0] addr,
  output logic              sample,
  output logic              last_sample,
  output logic              done
);
  localparam int unsigned LAT_W = (RD_LAT < 1) ? 1 : $clog2(RD_LAT + 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  logic [LAT_W-1:0] wcnt_q;

  assign sample      = busy && (wcnt_q == LAT_W'(RD_LAT));
  assign last_sample = sample && (addr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      capture <= 1'b0;
      addr    <= '0;
      wcnt_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_go) begin
        busy    <= 1'b1;
        capture <= 1'b1;
        addr    <= '0;
        wcnt_q  <= '0;
      end else if (!busy && tick) begin
        busy    <= 1'b1;
        capture <= 1'b0;
        addr    <= '0;
        wcnt_q  <= '0;
      end else if (sample) begin
        wcnt_q <= '0;
        if (last_sample) begin
          busy <= 1'b0;
          done <= 1'b1;
          addr <= '0;
        end else begin
          addr <= addr + 1'b1;
        end
      end else if (busy) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usm_ref_store.sv
module usm_ref_store #(
  parameter int unsigned NUM_REGS = 85,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DATA_W   = 38
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/usm_flip_count.sv
module usm_flip_count #(
  parameter int unsigned DATA_W = 38,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] rise_v,
  input  logic [DATA_W-1:0] fall_v,
  output logic [CNT_W-1:0]  total,
  output logic [CNT_W-1:0]  rise,
  output logic [CNT_W-1:0]  fall
);
  localparam int unsigned POP_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MAX = '1;

  function automatic logic [POP_W-1:0] pop(input logic [DATA_W-1:0] v);
    pop = '0;
    for (int i = 0; i < DATA_W; i++) pop = pop + POP_W'(v[i]);
  endfunction

  logic [POP_W-1:0] inc   [3];
  logic [CNT_W-1:0] cnt_q [3];

  // Rising and falling bits are disjoint, so their sum fits POP_W.
  always_comb begin
    inc[1] = pop(rise_v);
    inc[2] = pop(fall_v);
    inc[0] = inc[1] + inc[2];
  end

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt_q[g]} + (CNT_W + 1)'(inc[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q[g] <= '0;
      else if (clr) cnt_q[g] <= '0;
      else if (en)  cnt_q[g] <= sum[CNT_W] ? MAX : sum[CNT_W-1:0];
    end
  end

  assign total = cnt_q[0];
  assign rise  = cnt_q[1];
  assign fall  = cnt_q[2];
endmodule

// File: rtl/upset_scan_monitor.sv
module upset_scan_monitor #(
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned STEP_W  = 2,
  parameter int unsigned GRP0_N  = 64,
  parameter int unsigned GRP1_N  = 16,
  parameter int unsigned GRP2_N  = 4,
  parameter int unsigned GRP3_N  = 1,
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned SCAN_MS = 100,
  parameter int unsigned RD_LAT  = 1,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned NUM_REGS = GRP0_N + GRP1_N + GRP2_N + GRP3_N,
  localparam int unsigned DATA_W   = BASE_W + 3 * STEP_W,
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              update_mode_i,
  output logic [ADDR_W-1:0] rd_sel_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              armed_o,
  output logic              busy_o,
  output logic              pass_done_o,
  output logic [CNT_W-1:0]  upset_total_o,
  output logic [CNT_W-1:0]  upset_rise_o,
  output logic [CNT_W-1:0]  upset_fall_o,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic              last_valid_o
);
  localparam int unsigned PERIOD = CLK_HZ / 1000 * SCAN_MS;

  logic              start_go, tick, capture, sample, last_sample;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] mask, ref_rd, diff, rise_v, fall_v, wdata;
  logic              ref_we, count_en;

  assign start_go = start_i && !busy_o;

  usm_tick_gen #(.PERIOD(PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(armed_o), .tick(tick)
  );

  usm_scan_seq #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .tick(tick),
    .busy(busy_o), .capture(capture), .addr(addr), .sample(sample),
    .last_sample(last_sample), .done(pass_done_o)
  );

  assign rd_sel_o = addr;

  // Valid-bit mask of the addressed register (R4)
  always_comb begin
    int unsigned lim;
    lim = usm_pkg::width_of(int'(addr), GRP0_N, GRP1_N, GRP2_N, BASE_W, STEP_W);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(lim));
  end

  assign wdata    = rd_data_i & mask;
  assign diff     = (rd_data_i ^ ref_rd) & mask;
  assign rise_v   = diff & rd_data_i;
  assign fall_v   = diff & ref_rd;
  assign count_en = sample && !capture;
  assign ref_we   = sample && (capture || (update_mode_i && |diff));

  usm_ref_store #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ref (
    .clk(clk), .we(ref_we), .addr(addr), .wdata(wdata), .rdata(ref_rd)
  );

  usm_flip_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .en(count_en),
    .rise_v(rise_v), .fall_v(fall_v),
    .total(upset_total_o), .rise(upset_rise_o), .fall(upset_fall_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o      <= 1'b0;
      last_addr_o  <= '0;
      last_valid_o <= 1'b0;
    end else begin
      if (start_go)                      armed_o <= 1'b0;
      else if (last_sample && capture)   armed_o <= 1'b1;

      if (start_go) begin
        last_addr_o  <= '0;
        last_valid_o <= 1'b0;
      end else if (count_en && |diff) begin
        last_addr_o  <= addr;
        last_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/upset_scan_monitor_chk.sv
module upset_scan_monitor_chk #(
  parameter int unsigned NUM_REGS = 85,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CNT_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed_o,
  input logic              busy_o,
  input logic              pass_done_o,
  input logic [ADDR_W-1:0] rd_sel_o,
  input logic [CNT_W-1:0]  upset_total_o,
  input logic [CNT_W-1:0]  upset_rise_o,
  input logic [CNT_W-1:0]  upset_fall_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_sel_o) < NUM_REGS);

  assert_sel_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && rd_sel_o != $past(rd_sel_o))
      |-> rd_sel_o == $past(rd_sel_o) + 1'b1);

  assert_arm_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> pass_done_o);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |=> !pass_done_o);

  assert_split_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upset_total_o != MAX)
      |-> ({1'b0, upset_total_o} == {1'b0, upset_rise_o} + {1'b0, upset_fall_o}));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && $past(armed_o)) |-> upset_total_o >= $past(upset_total_o));

  assert_quiet_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |-> (upset_total_o == '0 && upset_rise_o == '0 && upset_fall_o == '0));
endmodule

bind upset_scan_monitor upset_scan_monitor_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .armed_o(armed_o), .busy_o(busy_o),
  .pass_done_o(pass_done_o), .rd_sel_o(rd_sel_o),
  .upset_total_o(upset_total_o), .upset_rise_o(upset_rise_o),
  .upset_fall_o(upset_fall_o)
);

// File: tb/upset_scan_monitor_tb.sv
`timescale 1ns/1ps
module upset_scan_monitor_tb;
  localparam int NR     = 85;
  localparam int DW     = 38;
  localparam int CW     = 8;
  localparam int PERIOD = 1000;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          update_mode_i = 1'b0;
  logic [6:0]    rd_sel_o;
  logic [DW-1:0] rd_data_i;
  logic          armed_o, busy_o, pass_done_o, last_valid_o;
  logic [CW-1:0] upset_total_o, upset_rise_o, upset_fall_o;
  logic [6:0]    last_addr_o;

  always #5 clk = ~clk;

  upset_scan_monitor #(.CLK_HZ(1_000_000), .SCAN_MS(1), .RD_LAT(1), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .update_mode_i(update_mode_i),
    .rd_sel_o(rd_sel_o), .rd_data_i(rd_data_i), .armed_o(armed_o), .busy_o(busy_o),
    .pass_done_o(pass_done_o), .upset_total_o(upset_total_o),
    .upset_rise_o(upset_rise_o), .upset_fall_o(upset_fall_o),
    .last_addr_o(last_addr_o), .last_valid_o(last_valid_o)
  );

  // Register bank with one cycle of read latency
  logic [DW-1:0] bank  [NR];
  logic [DW-1:0] ref_m [NR];
  always_ff @(posedge clk) rd_data_i <= bank[rd_sel_o];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  int exp_total = 0, exp_rise = 0, exp_fall = 0, exp_last = 0;
  bit exp_lv = 0;
  int t_prev = 0, t_done = 0;
  bit finished = 0;

  function automatic int bw(input int a);
    if (a < 64) return 32;
    if (a < 80) return 34;
    if (a < 84) return 36;
    return 38;
  endfunction

  function automatic logic [DW-1:0] bmask(input int a);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < bw(a));
    return m;
  endfunction

  function automatic int pc(input logic [DW-1:0] v);
    int n = 0;
    for (int i = 0; i < DW; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected effect of one checking pass on the counters and reference
  task automatic model_pass(input bit upd);
    for (int a = 0; a < NR; a++) begin
      logic [DW-1:0] d;
      d = (bank[a] ^ ref_m[a]) & bmask(a);
      if (d != '0) begin
        exp_total = sat(exp_total + pc(d));
        exp_rise  = sat(exp_rise + pc(d & bank[a]));
        exp_fall  = sat(exp_fall + pc(d & ref_m[a]));
        exp_last  = a;
        exp_lv    = 1;
        if (upd) ref_m[a] = bank[a] & bmask(a);
      end
    end
  endtask

  task automatic wait_pass();
    do @(negedge clk); while (!pass_done_o);
    t_prev = t_done;
    t_done = cyc;
  endtask

  task automatic check_counts(input string tag);
    chk({tag, " R5 total"}, int'(upset_total_o), exp_total);
    chk({tag, " R5 rise"},  int'(upset_rise_o),  exp_rise);
    chk({tag, " R5 fall"},  int'(upset_fall_o),  exp_fall);
    chk({tag, " R8 last_valid"}, int'(last_valid_o), int'(exp_lv));
    if (exp_lv) chk({tag, " R8 last_addr"}, int'(last_addr_o), exp_last);
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    void'($urandom(32'd2024));
    for (int a = 0; a < NR; a++) bank[a] = {$urandom, $urandom};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 total", int'(upset_total_o), 0);
    chk("R1 armed", int'(armed_o), 0);
    chk("R1 busy",  int'(busy_o), 0);
    chk("R1 last_valid", int'(last_valid_o), 0);
    chk("R1 sel", int'(rd_sel_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R10: capture pass
    do_start();
    t0 = cyc;
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R10 unarmed during capture", int'(armed_o), 0);
    wait_pass();
    chk("R2 capture length", t_done - t0, NR * 2);
    chk("R2 armed after capture", int'(armed_o), 1);
    chk("R10 no count in capture", int'(upset_total_o), 0);
    for (int a = 0; a < NR; a++) ref_m[a] = bank[a] & bmask(a);

    // Quiet check pass
    wait_pass();
    model_pass(0);
    check_counts("quiet");

    // R4: width map corners, update mode
    update_mode_i = 1'b1;
    bank[10][33] = ~bank[10][33];   // above width of a 32-bit register: ignored
    bank[70][33] = ~bank[70][33];   // inside a 34-bit register
    bank[84][37] = ~bank[84][37];   // top bit of the 38-bit register
    bank[3][0]   = ~bank[3][0];
    wait_pass();
    chk("R3 period", t_done - t_prev, PERIOD);
    model_pass(1);
    check_counts("R4 width");
    chk("R4 count of three", int'(upset_total_o), 3);
    chk("R8 last is 84", int'(last_addr_o), 84);

    // R6: persistent flip counted once in update mode
    wait_pass();
    chk("R3 period again", t_done - t_prev, PERIOD);
    model_pass(1);
    check_counts("R6 persist");
    chk("R6 no recount", int'(upset_total_o), 3);

    // R7: keep mode counts each pass, then returning to the image stops it
    update_mode_i = 1'b0;
    bank[20][5] = ~bank[20][5];
    wait_pass(); model_pass(0); check_counts("R7 pass1");
    wait_pass(); model_pass(0); check_counts("R7 pass2");
    chk("R7 counted twice", int'(upset_total_o), 5);
    bank[20][5] = ~bank[20][5];
    wait_pass(); model_pass(0); check_counts("R7 restored");
    chk("R7 restored no count", int'(upset_total_o), 5);

    // Random flip rounds with random mode
    for (int r = 0; r < 6; r++) begin
      int nf;
      update_mode_i = $urandom_range(0, 1);
      nf = $urandom_range(0, 4);
      for (int k = 0; k < nf; k++) begin
        int a, b;
        a = $urandom_range(0, NR - 1);
        b = $urandom_range(0, DW - 1);
        bank[a][b] = ~bank[a][b];
      end
      wait_pass();
      model_pass(update_mode_i);
      check_counts("R5 random");
    end

    // R2: start while busy is ignored
    do @(negedge clk); while (!busy_o);
    do_start();
    chk("R2 busy start ignored armed", int'(armed_o), 1);
    wait_pass();
    model_pass(update_mode_i);
    check_counts("R2 ignored start");

    // R2: restart clears counters and recaptures
    do_start();
    chk("R2 restart clears", int'(upset_total_o), 0);
    chk("R2 restart clears last", int'(last_valid_o), 0);
    wait_pass();
    for (int a = 0; a < NR; a++) ref_m[a] = bank[a] & bmask(a);
    exp_total = 0; exp_rise = 0; exp_fall = 0; exp_lv = 0;

    // R9: invert everything in keep mode -> saturation
    update_mode_i = 1'b0;
    for (int a = 0; a < NR; a++) bank[a] = ~bank[a];
    wait_pass(); model_pass(0); check_counts("R9 sat1");
    chk("R9 total saturated", int'(upset_total_o), CMAX);
    wait_pass(); model_pass(0); check_counts("R9 sat2");
    chk("R9 stays saturated", int'(upset_total_o), CMAX);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule